// File: doc/BRIEF.md
# Shared RAM Port Steering for CPU and DMA Engines

This block steers one port of a dual-port video or work RAM among three agents: the CPU, a block-transfer DMA engine (HDMA) and the sprite-table DMA engine (OAM DMA). The other RAM port belongs to the pixel unit alone and does not pass through this block. The block is not a general arbiter. It relies on the console's own access rules. While HDMA runs, the CPU is halted. While OAM DMA runs, the CPU may only touch high RAM, which is a separate store. Any CPU access that reaches this RAM during OAM DMA is therefore blocked.

Each clock edge registers the winning agent's address, write data and write enable onto the RAM port. The same edge updates a set of ownership flags. The RAM has a one-cycle read latency. A CPU read that is accepted, or blocked, returns a valid strobe two clock edges after the edge that sampled it. A blocked read returns all ones. A blocked write leaves the RAM unchanged. The DMA engines take their read data straight from the RAM port.

Top module: `ram_port_share`

## Requirements
- R1: While reset is asserted, and after it is released, the ownership flags, `ram_en`, `ram_we` and `cpu_rvalid` are all 0.
- R2: When `hdma_act` is 1 at a clock edge, then after that edge `own_hdma` is 1, `ram_en` is 1, and `ram_addr`, `ram_we` and `ram_wdata` carry the HDMA address, write flag and data.
- R3: `cpu_stall` is 1 in exactly those cycles in which `hdma_act` is 1. A CPU request made while the CPU is stalled is not accepted and does not produce a read strobe.
- R4: When OAM DMA is active and HDMA is not, then after the edge `own_oamdma` is 1, `ram_en` is 1, `ram_addr` equals `oamdma_addr` and `ram_we` is 0. OAM DMA only reads.
- R5: When HDMA and OAM DMA are active together, HDMA owns the port.
- R6: When neither DMA is active, a CPU request gives `own_cpu` = 1 after the edge and puts the CPU's address, write flag and data on the port. A CPU read raises `cpu_rvalid` for one cycle, one edge after the port cycle, with `cpu_rdata` equal to the RAM data.
- R7: A CPU write made during OAM DMA (without HDMA) never drives `ram_we` and leaves the RAM contents unchanged.
- R8: A CPU read made during OAM DMA (without HDMA) still gives `cpu_rvalid`, at the same timing as in R6, with `cpu_rdata` = all ones (FF).
- R9: At most one ownership flag is 1 in any cycle. The flags change only at clock edges.
- R10: When no agent requests, `ram_en` is 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access aimed at this RAM |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| cpu_addr | input | RAM_AW | CPU RAM address |
| cpu_wdata | input | DW | CPU write data |
| cpu_stall | output | 1 | Holds the CPU while HDMA runs |
| cpu_rvalid | output | 1 | CPU read data valid |
| cpu_rdata | output | DW | CPU read data (FF when blocked) |
| hdma_act | input | 1 | HDMA transfer cycle |
| hdma_we | input | 1 | HDMA write (1) or read (0) |
| hdma_addr | input | RAM_AW | HDMA RAM address |
| hdma_wdata | input | DW | HDMA write data |
| oamdma_act | input | 1 | OAM DMA running (reads source RAM) |
| oamdma_addr | input | RAM_AW | OAM DMA source address |
| own_hdma | output | 1 | HDMA owns the port this cycle |
| own_oamdma | output | 1 | OAM DMA owns the port this cycle |
| own_cpu | output | 1 | CPU owns the port this cycle |
| ram_en | output | 1 | Shared RAM port enable |
| ram_we | output | 1 | Shared RAM port write enable |
| ram_addr | output | RAM_AW | Shared RAM port address |
| ram_wdata | output | DW | Shared RAM port write data |
| ram_rdata | input | DW | Shared RAM port read data (one-cycle latency) |

## Verification
Three events can fall in the same cycle: a CPU request, an OAM DMA fetch and an HDMA transfer. The bench drives these together in several mixes. With all three present, HDMA must win, the CPU must be stalled, and no CPU read strobe may appear. With a CPU read or write during OAM DMA, the DMA fetch must own the port while the CPU gets FF or has its write silently dropped. A later plain CPU read of the same address then shows that the RAM contents did not change.

// File: rtl/ram_port_share.sv
module ram_port_share #(
  parameter int unsigned   RAM_AW   = 14,
  parameter int unsigned   DW       = 8,
  parameter logic [DW-1:0] OPEN_BUS = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [RAM_AW-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  output logic              cpu_stall,
  output logic              cpu_rvalid,
  output logic [DW-1:0]     cpu_rdata,
  input  logic              hdma_act,
  input  logic              hdma_we,
  input  logic [RAM_AW-1:0] hdma_addr,
  input  logic [DW-1:0]     hdma_wdata,
  input  logic              oamdma_act,
  input  logic [RAM_AW-1:0] oamdma_addr,
  output logic              own_hdma,
  output logic              own_oamdma,
  output logic              own_cpu,
  output logic              ram_en,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [DW-1:0]     ram_wdata,
  input  logic [DW-1:0]     ram_rdata
);

  logic pick_h, pick_o, pick_c, cpu_blk;
  logic rd_s1, blk_s1, blk_s2;

  assign pick_h  = hdma_act;
  assign pick_o  = !hdma_act && oamdma_act;
  assign pick_c  = !hdma_act && !oamdma_act && cpu_req;
  assign cpu_blk = pick_o && cpu_req;

  assign cpu_stall = hdma_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_hdma   <= 1'b0;
      own_oamdma <= 1'b0;
      own_cpu    <= 1'b0;
      ram_en     <= 1'b0;
      ram_we     <= 1'b0;
      ram_addr   <= '0;
      ram_wdata  <= '0;
      rd_s1      <= 1'b0;
      blk_s1     <= 1'b0;
      cpu_rvalid <= 1'b0;
      blk_s2     <= 1'b0;
    end else begin
      own_hdma   <= pick_h;
      own_oamdma <= pick_o;
      own_cpu    <= pick_c;
      ram_en     <= pick_h || pick_o || pick_c;
      ram_we     <= (pick_h && hdma_we) || (pick_c && cpu_we);
      ram_addr   <= pick_h ? hdma_addr : (pick_o ? oamdma_addr : cpu_addr);
      ram_wdata  <= pick_h ? hdma_wdata : cpu_wdata;
      rd_s1      <= (pick_c || cpu_blk) && !cpu_we;
      blk_s1     <= cpu_blk;
      cpu_rvalid <= rd_s1;
      blk_s2     <= blk_s1;
    end
  end

  assign cpu_rdata = blk_s2 ? OPEN_BUS : ram_rdata;

endmodule

module ram_port_share_chk #(
  parameter int unsigned RAM_AW = 14,
  parameter int unsigned DW     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic              hdma_act,
  input logic              oamdma_act,
  input logic              own_hdma,
  input logic              own_oamdma,
  input logic              own_cpu,
  input logic              ram_en,
  input logic              ram_we,
  input logic              cpu_rvalid,
  input logic [DW-1:0]     cpu_rdata,
  input logic [RAM_AW-1:0] ram_addr
);

  a_r9_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({own_hdma, own_oamdma, own_cpu}));

  a_r2_hdma_owns: assert property (@(posedge clk) disable iff (!rst_n)
    hdma_act |=> own_hdma && ram_en);

  a_r5_hdma_over_oam: assert property (@(posedge clk) disable iff (!rst_n)
    (hdma_act && oamdma_act) |=> (own_hdma && !own_oamdma));

  a_r4_oam_reads_only: assert property (@(posedge clk) disable iff (!rst_n)
    own_oamdma |-> !ram_we);

  a_r6_cpu_owns: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !hdma_act && !oamdma_act) |=> (own_cpu && ram_en));

  a_r7_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && oamdma_act && !hdma_act) |=> !ram_we);

  a_r8_blocked_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we && oamdma_act && !hdma_act) |=> ##1 (cpu_rvalid && (cpu_rdata == '1)));

  a_r10_idle_port: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_req && !hdma_act && !oamdma_act) |=> !ram_en);

  a_r3_stall_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (hdma_act && !own_cpu && !own_oamdma) |=> !cpu_rvalid);

endmodule

bind ram_port_share ram_port_share_chk #(.RAM_AW(RAM_AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
  .hdma_act(hdma_act), .oamdma_act(oamdma_act),
  .own_hdma(own_hdma), .own_oamdma(own_oamdma), .own_cpu(own_cpu),
  .ram_en(ram_en), .ram_we(ram_we), .cpu_rvalid(cpu_rvalid),
  .cpu_rdata(cpu_rdata), .ram_addr(ram_addr)
);

// File: tb/sim_ram_port_share.sv
module sim_ram_port_share;
  localparam int AW = 14;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_stall, cpu_rvalid;
  logic [DW-1:0] cpu_rdata;
  logic hdma_act = 1'b0, hdma_we = 1'b0;
  logic [AW-1:0] hdma_addr = '0;
  logic [DW-1:0] hdma_wdata = '0;
  logic oamdma_act = 1'b0;
  logic [AW-1:0] oamdma_addr = '0;
  logic own_hdma, own_oamdma, own_cpu, ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;
  logic [DW-1:0] ram_rdata;

  always #2 clk = ~clk;

  ram_port_share #(.RAM_AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_stall(cpu_stall), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .hdma_act(hdma_act), .hdma_we(hdma_we), .hdma_addr(hdma_addr), .hdma_wdata(hdma_wdata),
    .oamdma_act(oamdma_act), .oamdma_addr(oamdma_addr),
    .own_hdma(own_hdma), .own_oamdma(own_oamdma), .own_cpu(own_cpu),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata)
  );

  // RAM behind the shared port: one-cycle read latency
  logic [DW-1:0] mem [256];
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[ram_addr[7:0]] <= ram_wdata;
      ram_rdata <= mem[ram_addr[7:0]];
    end
  end

  typedef struct {
    string         tag;
    logic [2:0]    own;
    logic          en;
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic          rvalid;
    logic [DW-1:0] rdata;
  } item_t;

  item_t sb[$];
  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] exp_mem [256];
  logic          pend_rd = 1'b0;
  logic [DW-1:0] pend_data = '0;

  task automatic check(input string tag, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag,
                     input logic cr, input logic cw, input logic [AW-1:0] ca, input logic [DW-1:0] cd,
                     input logic ha, input logic hw, input logic [AW-1:0] hadr, input logic [DW-1:0] hd,
                     input logic oa, input logic [AW-1:0] oadr);
    item_t it;
    @(negedge clk);
    cpu_req = cr; cpu_we = cw; cpu_addr = ca; cpu_wdata = cd;
    hdma_act = ha; hdma_we = hw; hdma_addr = hadr; hdma_wdata = hd;
    oamdma_act = oa; oamdma_addr = oadr;
    #1;
    check({tag, " R3 stall"}, cpu_stall == ha, 32'(cpu_stall), 32'(ha));
    it.tag = tag;
    it.rvalid = pend_rd;
    it.rdata = pend_data;
    it.wdata = 'x;
    if (ha) begin
      it.own = 3'b100; it.en = 1'b1; it.we = hw; it.addr = hadr; it.wdata = hd;
    end else if (oa) begin
      it.own = 3'b010; it.en = 1'b1; it.we = 1'b0; it.addr = oadr;
    end else if (cr) begin
      it.own = 3'b001; it.en = 1'b1; it.we = cw; it.addr = ca; it.wdata = cd;
    end else begin
      it.own = 3'b000; it.en = 1'b0; it.we = 1'b0; it.addr = 'x;
    end
    if (!ha && cr && !cw) begin
      pend_rd = 1'b1;
      pend_data = oa ? 8'hFF : exp_mem[ca[7:0]];
    end else begin
      pend_rd = 1'b0;
    end
    if (ha && hw) exp_mem[hadr[7:0]] = hd;
    else if (!oa && cr && cw) exp_mem[ca[7:0]] = cd;
    sb.push_back(it);
  endtask

  task automatic idle(input string tag);
    cyc(tag, 0, 0, '0, '0, 0, 0, '0, '0, 0, '0);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t e;
        e = sb.pop_front();
        check({e.tag, " own"}, {own_hdma, own_oamdma, own_cpu} == e.own,
              32'({own_hdma, own_oamdma, own_cpu}), 32'(e.own));
        check({e.tag, " en/we"}, {ram_en, ram_we} == {e.en, e.we},
              32'({ram_en, ram_we}), 32'({e.en, e.we}));
        if (e.en) check({e.tag, " addr"}, ram_addr == e.addr, 32'(ram_addr), 32'(e.addr));
        if (e.en && e.we) check({e.tag, " wdata"}, ram_wdata == e.wdata, 32'(ram_wdata), 32'(e.wdata));
        check({e.tag, " rvalid"}, cpu_rvalid == e.rvalid, 32'(cpu_rvalid), 32'(e.rvalid));
        if (e.rvalid) check({e.tag, " rdata"}, cpu_rdata == e.rdata, 32'(cpu_rdata), 32'(e.rdata));
      end
    end
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) exp_mem[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset flags", {own_hdma, own_oamdma, own_cpu, ram_en, ram_we, cpu_rvalid} == 6'b0,
          32'({own_hdma, own_oamdma, own_cpu, ram_en, ram_we, cpu_rvalid}), 32'h0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after release", {own_hdma, own_oamdma, own_cpu, ram_en, cpu_rvalid} == 5'b0,
          32'({own_hdma, own_oamdma, own_cpu, ram_en, cpu_rvalid}), 32'h0);

    // R2 / R3: HDMA writes while the CPU asks to read (stalled)
    cyc("R2 hdma wr a", 1, 0, 14'd10, 8'h00, 1, 1, 14'd10, 8'hA5, 0, '0);
    cyc("R2 hdma wr b", 1, 0, 14'd10, 8'h00, 1, 1, 14'd11, 8'h5A, 0, '0);
    cyc("R2 hdma rd",   0, 0, '0,     8'h00, 1, 0, 14'd11, 8'h00, 0, '0);
    // R5: HDMA and OAM DMA together; R9 all three requesting
    cyc("R5 hdma beats oam", 0, 0, '0, 8'h00, 1, 1, 14'd12, 8'h77, 1, 14'd40);
    cyc("R9 three agents",   1, 1, 14'd13, 8'h11, 1, 1, 14'd14, 8'h22, 1, 14'd41);
    idle("R10 idle");
    // R6: plain CPU traffic
    cyc("R6 cpu rd 10", 1, 0, 14'd10, 8'h00, 0, 0, '0, '0, 0, '0);
    cyc("R6 cpu wr 20", 1, 1, 14'd20, 8'h3C, 0, 0, '0, '0, 0, '0);
    cyc("R6 cpu rd 20", 1, 0, 14'd20, 8'h00, 0, 0, '0, '0, 0, '0);
    cyc("R6 cpu rd 12", 1, 0, 14'd12, 8'h00, 0, 0, '0, '0, 0, '0);
    // R4 / R7 / R8: OAM DMA with CPU traffic
    cyc("R4 oam alone",    0, 0, '0,     8'h00, 0, 0, '0, '0, 1, 14'd11);
    cyc("R7 cpu wr block", 1, 1, 14'd20, 8'h99, 0, 0, '0, '0, 1, 14'd12);
    cyc("R8 cpu rd block", 1, 0, 14'd10, 8'h00, 0, 0, '0, '0, 1, 14'd13);
    cyc("R8 rd blk again", 1, 0, 14'd20, 8'h00, 0, 0, '0, '0, 1, 14'd14);
    cyc("R7 rd after",     1, 0, 14'd20, 8'h00, 0, 0, '0, '0, 0, '0);
    cyc("R3 rd then stall", 1, 0, 14'd11, 8'h00, 0, 0, '0, '0, 0, '0);
    cyc("R3 stalled rd",   1, 0, 14'd11, 8'h00, 1, 0, 14'd10, '0, 0, '0);
    idle("R10 flush a");
    idle("R10 flush b");
    idle("R10 flush c");
    @(posedge clk); #2;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule